// File: doc/BRIEF.md
# Trigger Buffer Occupancy Emulator

This block sits away from the detector, beside the trigger distribution. A large set of identical front-end chips runs in lockstep, and each one holds accepted events in a small readout buffer. The block keeps one copy of that buffer state for all of them. It counts an event in when a trigger is accepted. It counts the event out when a readout frame of fixed length has finished draining. Each frame is a header of configurable length followed by a fixed number of samples, and the samples go out at half the system clock rate. The frame length never depends on how many channels were hit, so the emulator needs no feedback from the chips.

The count drives a trigger-inhibit output. The inhibit rises while the occupancy stands one slot below the configured depth. A trigger that arrives in the same cycle as the inhibit is therefore also refused, and the real buffers keep a spare slot. A busy flag shows when a frame is draining. Frames drain back to back for as long as events are waiting. The trigger strobe is a plain one-cycle pulse with no handshake: the inhibit is the only form of back-pressure, and a strobe raised while the inhibit is high is dropped.

Change the depth setting only while reset is held, or while the occupancy is below the new limit. The header length may change at any time and takes effect at the next frame boundary.

Top module: `trig_occ_emulator`

## Requirements
- R1: A synchronous active-high reset sets occupancy to 0, stops any frame in progress and holds busy low.
- R2: A trigger strobe seen while inhibit is low raises the occupancy by exactly one at the next clock edge, unless a frame completes on that same edge.
- R3: Inhibit is driven combinationally from the present occupancy. It is high exactly when the occupancy is greater than or equal to the effective depth minus one. The effective depth is cfg_depth, except that 0 selects the default of 10 and values above MAX_DEPTH are clamped. A strobe seen while inhibit is high leaves the occupancy unchanged.
- R4: With the depth setting held constant, the occupancy never exceeds the effective depth minus one.
- R5: When no frame is draining and the occupancy is non-zero, a frame starts at the next edge. Busy then stays high for exactly (header length + 128) × 2 cycles. The occupancy drops by one on the edge that ends the frame.
- R6: If events remain after a frame ends, the next frame starts with no idle cycle, and busy stays high without a gap.
- R7: When an accepted trigger and a frame completion fall on the same edge, the occupancy keeps its value and draining continues.
- R8: The header length is sampled when a frame starts. A change made during a frame sets the length of the next frame only.
- R9: Busy is never high while the occupancy is 0, and busy falls once the last waiting event has drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (twice the sample rate) |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | One-cycle trigger strobe |
| cfg_depth | input | DEPTH_W | Buffer depth in frames, 0 selects default |
| cfg_hdr_len | input | HDR_W | Header length in sample periods |
| inhibit_o | output | 1 | Trigger inhibit, combinational from occupancy |
| occ_o | output | DEPTH_W | Current emulated occupancy |
| busy_o | output | 1 | A frame is draining |

## Verification
Two events can land on the same edge: a trigger being accepted and a frame finishing its drain. The bench provokes this by raising a strobe on the exact edge where a single event's frame ends. It then requires that the occupancy holds at one, that busy stays high, and that a fresh frame of full length follows. A second case pairs a frame completion with a strobe that arrives while the block is inhibited. There the bench requires that the occupancy drops by one and that the inhibit clears on the following cycle.

// File: rtl/occ_emu_pkg.sv
package occ_emu_pkg;

  typedef enum logic {
    DR_IDLE = 1'b0,
    DR_RUN  = 1'b1
  } drain_st_e;

  // clock cycles taken by one frame: header and samples, each sample
  // lasting cps system clocks
  function automatic int unsigned frame_clks(input int unsigned hdr,
                                             input int unsigned smp,
                                             input int unsigned cps);
    return (hdr + smp) * cps;
  endfunction

endpackage

// File: rtl/occ_limit.sv
module occ_limit #(
  parameter int unsigned DEPTH_W   = 4,
  parameter int unsigned MAX_DEPTH = 15,
  parameter int unsigned DEF_DEPTH = 10
) (
  input  logic [DEPTH_W-1:0] cfg_depth,
  input  logic [DEPTH_W-1:0] occ,
  output logic [DEPTH_W-1:0] limit,
  output logic               inhibit
);
  localparam logic [DEPTH_W-1:0] DEF_V = DEPTH_W'(DEF_DEPTH);
  localparam logic [DEPTH_W-1:0] MAX_V = DEPTH_W'(MAX_DEPTH);

  logic [DEPTH_W-1:0] eff_depth;

  always_comb begin
    if (cfg_depth == '0)
      eff_depth = DEF_V;
    else if (cfg_depth > MAX_V)
      eff_depth = MAX_V;
    else
      eff_depth = cfg_depth;
  end

  // one spare slot: block while the last usable slot is taken
  assign limit   = eff_depth - DEPTH_W'(1);
  assign inhibit = (occ >= limit);

endmodule

// File: rtl/occ_tracker.sv
module occ_tracker #(
  parameter int unsigned OCC_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             dec,
  output logic [OCC_W-1:0] occ
);

  always_ff @(posedge clk) begin
    if (rst) begin
      occ <= '0;
    end else begin
      unique case ({inc, dec})
        2'b10:   occ <= occ + OCC_W'(1);
        2'b01:   occ <= occ - OCC_W'(1);
        default: occ <= occ;
      endcase
    end
  end

  // a completion only happens with an event present (R5)
  p_no_underflow_r5: assert property (@(posedge clk) disable iff (rst)
    dec |-> (occ != '0));

endmodule

// File: rtl/drain_timer.sv
module drain_timer
  import occ_emu_pkg::*;
#(
  parameter int unsigned CNT_W   = 9,
  parameter int unsigned HDR_W   = 5,
  parameter int unsigned SAMPLES = 128,
  parameter int unsigned CPS     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pending,
  input  logic             keep_going,
  input  logic [HDR_W-1:0] hdr_len,
  output logic             busy,
  output logic             done
);

  drain_st_e        st;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] load_val;

  assign load_val = CNT_W'(frame_clks(32'(hdr_len), SAMPLES, CPS)) - CNT_W'(1);
  assign busy     = (st == DR_RUN);
  assign done     = (st == DR_RUN) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= DR_IDLE;
      cnt <= '0;
    end else begin
      unique case (st)
        DR_IDLE: begin
          if (pending) begin
            st  <= DR_RUN;
            cnt <= load_val;
          end
        end
        DR_RUN: begin
          if (cnt == '0) begin
            if (keep_going) cnt <= load_val;
            else            st  <= DR_IDLE;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        default: st <= DR_IDLE;
      endcase
    end
  end

  // a frame under way runs on until its counter expires (R5)
  p_frame_holds_r5: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> busy);

endmodule

// File: rtl/trig_occ_emulator.sv
module trig_occ_emulator #(
  parameter int unsigned DEPTH_W         = 4,
  parameter int unsigned MAX_DEPTH       = 15,
  parameter int unsigned DEF_DEPTH       = 10,
  parameter int unsigned HDR_W           = 5,
  parameter int unsigned SAMPLES         = 128,
  parameter int unsigned CLKS_PER_SAMPLE = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               trig_i,
  input  logic [DEPTH_W-1:0] cfg_depth,
  input  logic [HDR_W-1:0]   cfg_hdr_len,
  output logic               inhibit_o,
  output logic [DEPTH_W-1:0] occ_o,
  output logic               busy_o
);
  localparam int unsigned MAX_FRAME = ((1 << HDR_W) - 1 + SAMPLES) * CLKS_PER_SAMPLE;
  localparam int unsigned CNT_W     = $clog2(MAX_FRAME + 1);

  logic [DEPTH_W-1:0] occ;
  logic [DEPTH_W-1:0] limit;
  logic               inhibit;
  logic               accept;
  logic               done;
  logic               busy;
  logic               keep_going;

  occ_limit #(
    .DEPTH_W  (DEPTH_W),
    .MAX_DEPTH(MAX_DEPTH),
    .DEF_DEPTH(DEF_DEPTH)
  ) u_limit (
    .cfg_depth(cfg_depth),
    .occ      (occ),
    .limit    (limit),
    .inhibit  (inhibit)
  );

  assign accept     = trig_i & ~inhibit;
  assign keep_going = (occ > DEPTH_W'(1)) | accept;

  occ_tracker #(
    .OCC_W(DEPTH_W)
  ) u_track (
    .clk(clk),
    .rst(rst),
    .inc(accept),
    .dec(done),
    .occ(occ)
  );

  drain_timer #(
    .CNT_W  (CNT_W),
    .HDR_W  (HDR_W),
    .SAMPLES(SAMPLES),
    .CPS    (CLKS_PER_SAMPLE)
  ) u_drain (
    .clk       (clk),
    .rst       (rst),
    .pending   (occ != '0),
    .keep_going(keep_going),
    .hdr_len   (cfg_hdr_len),
    .busy      (busy),
    .done      (done)
  );

  assign inhibit_o = inhibit;
  assign occ_o     = occ;
  assign busy_o    = busy;

  p_count_up_r2: assert property (@(posedge clk) disable iff (rst)
    (trig_i && !inhibit_o && !done) |=> ((occ_o - $past(occ_o)) == DEPTH_W'(1)));

  p_blocked_r3: assert property (@(posedge clk) disable iff (rst)
    (trig_i && inhibit_o && !done) |=> $stable(occ_o));

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    occ_o <= limit);

  p_start_next_r5: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && occ_o != '0) |=> busy_o);

  p_no_gap_r6: assert property (@(posedge clk) disable iff (rst)
    (done && occ_o > DEPTH_W'(1)) |=> busy_o);

  p_same_edge_r7: assert property (@(posedge clk) disable iff (rst)
    (done && trig_i && !inhibit_o) |=> ($stable(occ_o) && busy_o));

  p_busy_needs_event_r9: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (occ_o != '0));

endmodule

// File: tb/trig_occ_emulator_test.sv
module trig_occ_emulator_test;
  localparam int DW = 4;
  localparam int HW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          trig = 1'b0;
  logic [DW-1:0] depth = DW'(4);
  logic [HW-1:0] hdr = HW'(4);
  logic          inhibit;
  logic [DW-1:0] occ;
  logic          busy;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  trig_occ_emulator uut (
    .clk        (clk),
    .rst        (rst),
    .trig_i     (trig),
    .cfg_depth  (depth),
    .cfg_hdr_len(hdr),
    .inhibit_o  (inhibit),
    .occ_o      (occ),
    .busy_o     (busy)
  );

  function automatic int flen(input int h);
    return (h + 128) * 2;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input int d, input int h);
    rst = 1'b1; trig = 1'b0; depth = DW'(d); hdr = HW'(h);
    cyc(3);
    rst = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1; trig = 1'b1; depth = DW'(4); hdr = HW'(4);
    cyc(3);
    check("R1 occ in reset", int'(occ), 0);
    check("R1 busy in reset", int'(busy), 0);
    check("R1 inhibit in reset", int'(inhibit), 0);
    trig = 1'b0; rst = 1'b0;
  endtask

  task automatic t_single;
    int f = flen(4);
    do_reset(4, 4);
    trig = 1'b1; cyc(1); trig = 1'b0;
    check("R2 occ after one trigger", int'(occ), 1);
    check("R5 busy one edge later", int'(busy), 0);
    cyc(1);
    check("R5 frame started", int'(busy), 1);
    cyc(f - 1);
    check("R5 busy on last frame cycle", int'(busy), 1);
    check("R5 occ before frame end", int'(occ), 1);
    cyc(1);
    check("R5 occ after frame end", int'(occ), 0);
    check("R9 busy falls when empty", int'(busy), 0);
  endtask

  task automatic t_back_to_back;
    int f = flen(4);
    int lows = 0;
    do_reset(8, 4);
    trig = 1'b1; cyc(3); trig = 1'b0;
    check("R2 occ after three triggers", int'(occ), 3);
    for (int i = 0; i < f - 2; i++) begin cyc(1); if (!busy) lows++; end
    check("R6 occ before first end", int'(occ), 3);
    cyc(1);
    check("R6 occ after first end", int'(occ), 2);
    for (int i = 0; i < f; i++) begin cyc(1); if (!busy) lows++; end
    check("R6 occ after second end", int'(occ), 1);
    check("R6 busy gaps between frames", lows, 0);
    cyc(f);
    check("R9 occ drained", int'(occ), 0);
    check("R9 busy low when drained", int'(busy), 0);
  endtask

  task automatic t_inhibit;
    int f = flen(4);
    do_reset(4, 4);
    trig = 1'b1; cyc(3);
    check("R3 occ reaches limit", int'(occ), 3);
    check("R3 inhibit at depth-1", int'(inhibit), 1);
    cyc(10);
    check("R4 occ capped under strobes", int'(occ), 3);
    cyc(f - 12);
    check("R3 still inhibited before drain", int'(inhibit), 1);
    cyc(1);
    check("R7 blocked strobe with completion", int'(occ), 2);
    check("R3 inhibit clears", int'(inhibit), 0);
    cyc(1);
    check("R2 strobe accepted again", int'(occ), 3);
    trig = 1'b0;
  endtask

  task automatic t_same_edge;
    int f = flen(4);
    do_reset(4, 4);
    trig = 1'b1; cyc(1); trig = 1'b0;
    cyc(f);
    trig = 1'b1; cyc(1); trig = 1'b0;
    check("R7 occ kept on shared edge", int'(occ), 1);
    check("R7 draining continues", int'(busy), 1);
    cyc(f - 1);
    check("R7 new frame full length", int'(busy), 1);
    cyc(1);
    check("R7 drained after new frame", int'(occ), 0);
  endtask

  task automatic t_depth_cfg;
    do_reset(1, 4);
    check("R3 depth one inhibits at zero", int'(inhibit), 1);
    trig = 1'b1; cyc(1); trig = 1'b0;
    check("R3 strobe ignored at depth one", int'(occ), 0);
    check("R3 no frame at depth one", int'(busy), 0);
    do_reset(0, 4);
    trig = 1'b1; cyc(12); trig = 1'b0;
    check("R3 default depth limit", int'(occ), 9);
    check("R3 default depth inhibit", int'(inhibit), 1);
  endtask

  task automatic t_hdr_latch;
    int f = flen(4);
    int g = flen(10);
    do_reset(4, 4);
    trig = 1'b1; cyc(2); trig = 1'b0;
    hdr = HW'(10);
    cyc(f - 1);
    check("R8 first frame keeps old length", int'(occ), 2);
    cyc(1);
    check("R8 first frame ends on time", int'(occ), 1);
    cyc(g - 1);
    check("R8 second frame uses new length", int'(occ), 1);
    cyc(1);
    check("R8 second frame ends", int'(occ), 0);
    hdr = HW'(4);
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_single();
    t_back_to_back();
    t_inhibit();
    t_same_edge();
    t_depth_cfg();
    t_hdr_latch();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule